// File: doc/BRIEF.md
# Multi-Requester Power Domain Vote Controller

This block collects power votes for a group of power domains from several independent requesters, such as a main processor and a handful of remote cores. It drives one power-switch request line per domain and keeps a domain powered for as long as any requester still holds a vote for it. Each requester writes through a small register port and names itself on `wr_id`. A 1 in bit *d* of a command register acts on domain *d*. Several domains may be addressed in one write, and each then runs its own sequence.

Each domain has its own small sequencer. A command is accepted only while that domain reports itself idle. The command then passes through a short start phase of `PREP_CYC` cycles. If the vote change moves the domain between "no voters" and "some voters", the sequencer runs a handshake with the power switch. When a domain is switched off, the sequencer waits `SETTLE_CYC` cycles before it trusts the switch acknowledge. Software judges that a command has finished by combining the idle, powered and in-flight status bits. The command bits also read back in patterns that show when the command was picked up.

Top module: `hwv_vote_ctrl`

## Requirements
- R1: After reset, for every domain: the ON-command readback and the idle bit read 1; the OFF-command readback, the powered bit and both in-flight bits read 0; `pwr_req` is 0.
- R2: The register addresses are: 0 ON-command, 1 OFF-command, 2 idle, 3 powered, 4 ON-in-flight, 5 OFF-in-flight, 6 vote view. At address 6, bit d is the vote of requester `rd_id` for domain d. Address 7 reads 0. In every register, bit d belongs to domain d. A write to any address other than 0 or 1 changes no state.
- R3: Writing 1 to bit d at address 0 while domain d is idle has this effect on the next cycle: the ON-command readback bit reads 0, the idle bit reads 0 and the ON-in-flight bit reads 1. The readback bit returns to 1 `PREP_CYC` cycles after the write.
- R4: Writing 1 to bit d at address 1 while domain d is idle has this effect on the next cycle: the OFF-command readback bit reads 1, the idle bit reads 0 and the OFF-in-flight bit reads 1. The readback bit returns to 0 `PREP_CYC` cycles after the write.
- R5: A command write to a domain whose idle bit is 0 has no effect on its vote or its sequence. A write from a `wr_id` of `NUM_REQ` or more has no effect at all.
- R6: Each requester's vote is tracked on its own. `pwr_req[d]` rises only when the vote set of domain d goes from empty to non-empty. It falls only when that set becomes empty.
- R7: The powered bit changes only after the switch acknowledge. It is set on a 1 at `pwr_ack[d]` while a power-up is pending. It is cleared on a 0 at `pwr_ack[d]` after the settle wait. It never changes on the vote write itself.
- R8: After `pwr_req[d]` falls, the domain stays busy and powered for at least `SETTLE_CYC` cycles before the acknowledge is looked at.
- R9: A power-up ends with the idle and powered bits at 1 and ON-in-flight at 0. A power-down ends with the idle bit at 1, OFF-in-flight at 0 and the powered bit at 0.
- R10: Domains are independent. One write may start commands on several domains at once, and each of them completes on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_id | input | IDW | Requester number of the write |
| wr_addr | input | 3 | Write address |
| wr_data | input | NUM_DOM | Write data, one bit per domain |
| rd_id | input | IDW | Requester selected for the vote view |
| rd_addr | input | 3 | Read address |
| rd_data | output | NUM_DOM | Read data, one bit per domain, combinational |
| pwr_req | output | NUM_DOM | Power-switch request per domain |
| pwr_ack | input | NUM_DOM | Power-switch acknowledge per domain |

## Verification
The bench builds the block with four domains and three requesters. Three requesters make a shared vote possible, and they also leave one encodable requester number (3) unused, so the out-of-range write path can be exercised. `PREP_CYC` = 2 is long enough to see the readback bits in their transient state before they return. `SETTLE_CYC` = 8 is shorter than the real settle time, so the power-down wait can be timed exactly within a short run. The bench models the power switch as an acknowledge that follows `pwr_req` three cycles late. With this model the acknowledge drops before the settle wait ends, so a design that sampled the acknowledge too early would finish too soon and be caught.

// File: rtl/hwv_pkg.sv
package hwv_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_ON_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_OFF_CMD = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_IDLE    = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PWRD    = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ON_BUSY = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_OFF_BSY = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_VOTE    = 3'd6;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_START,
        DS_WAIT_ON,
        DS_SETTLE,
        DS_WAIT_OFF
    } dom_state_e;
endpackage

// File: rtl/hwv_domain.sv
module hwv_domain
    import hwv_pkg::*;
#(
    parameter int NUM_REQ    = 3,
    parameter int PREP_CYC   = 2,
    parameter int SETTLE_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_on,
    input  logic               cmd_off,
    input  logic [NUM_REQ-1:0] req_oh,
    input  logic               pwr_ack,
    output logic               pwr_req,
    output logic               on_rb,
    output logic               off_rb,
    output logic               idle,
    output logic               powered,
    output logic               on_busy,
    output logic               off_busy,
    output logic [NUM_REQ-1:0] votes
);
    localparam int CNT_MAX = (SETTLE_CYC > PREP_CYC) ? SETTLE_CYC : PREP_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        dom_state_e         st;
        logic               op_on;
        logic [CW-1:0]      cnt;
        logic [NUM_REQ-1:0] vote;
        logic               en;
        logic               preq;
        logic               on_rb;
        logic               off_rb;
    } dom_regs_t;

    dom_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            DS_IDLE: begin
                if (cmd_on || cmd_off) begin
                    r_d.st    = DS_START;
                    r_d.op_on = cmd_on;
                    r_d.cnt   = CW'(PREP_CYC - 1);
                    if (cmd_on) begin
                        r_d.vote  = r_q.vote | req_oh;
                        r_d.on_rb = 1'b0;
                    end else begin
                        r_d.vote   = r_q.vote & ~req_oh;
                        r_d.off_rb = 1'b1;
                    end
                end
            end
            DS_START: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.op_on) begin
                    r_d.on_rb = 1'b1;
                    if ((r_q.vote != '0) && !r_q.en) begin
                        r_d.st   = DS_WAIT_ON;
                        r_d.preq = 1'b1;
                    end else begin
                        r_d.st = DS_IDLE;
                    end
                end else begin
                    r_d.off_rb = 1'b0;
                    if ((r_q.vote == '0) && r_q.en) begin
                        r_d.st   = DS_SETTLE;
                        r_d.preq = 1'b0;
                        r_d.cnt  = CW'(SETTLE_CYC - 1);
                    end else begin
                        r_d.st = DS_IDLE;
                    end
                end
            end
            DS_WAIT_ON: begin
                if (pwr_ack) begin
                    r_d.en = 1'b1;
                    r_d.st = DS_IDLE;
                end
            end
            DS_SETTLE: begin
                if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
                else               r_d.st  = DS_WAIT_OFF;
            end
            DS_WAIT_OFF: begin
                if (!pwr_ack) begin
                    r_d.en = 1'b0;
                    r_d.st = DS_IDLE;
                end
            end
            default: r_d.st = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= DS_IDLE;
            r_q.on_rb  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle     = (r_q.st == DS_IDLE);
    assign on_busy  = !idle && r_q.op_on;
    assign off_busy = !idle && !r_q.op_on;
    assign powered  = r_q.en;
    assign pwr_req  = r_q.preq;
    assign on_rb    = r_q.on_rb;
    assign off_rb   = r_q.off_rb;
    assign votes    = r_q.vote;

    // Checker state: cycles since the power request was last high.
    logic [CW:0] off_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      off_age_q <= '0;
        else if (r_q.preq)               off_age_q <= '0;
        else if (off_age_q != '1)        off_age_q <= off_age_q + 1'b1;
    end

    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && (cmd_on || cmd_off)) |=> $stable(votes));
    // R7
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |-> $past(pwr_ack));
    // R7
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered) |-> !$past(pwr_ack));
    // R6
    idle_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (powered == (votes != '0)));
    // R8
    settle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered) |-> (off_age_q >= (CW+1)'(SETTLE_CYC)));
    // R3
    on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_busy) |-> !on_rb);
    // R4
    off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_busy) |-> off_rb);
endmodule

// File: rtl/hwv_rd_mux.sv
module hwv_rd_mux
    import hwv_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int NUM_REQ = 3,
    parameter int IDW     = 2
) (
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [IDW-1:0]                   rd_id,
    input  logic [NUM_DOM-1:0]               on_rb,
    input  logic [NUM_DOM-1:0]               off_rb,
    input  logic [NUM_DOM-1:0]               idle,
    input  logic [NUM_DOM-1:0]               powered,
    input  logic [NUM_DOM-1:0]               on_busy,
    input  logic [NUM_DOM-1:0]               off_busy,
    input  logic [NUM_DOM-1:0][NUM_REQ-1:0]  votes,
    output logic [NUM_DOM-1:0]               rd_data
);
    logic [NUM_DOM-1:0] vote_view;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_view
        always_comb begin
            vote_view[d] = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (int'(rd_id) == r) vote_view[d] = votes[d][r];
            end
        end
    end

    always_comb begin
        case (rd_addr)
            ADR_ON_CMD:  rd_data = on_rb;
            ADR_OFF_CMD: rd_data = off_rb;
            ADR_IDLE:    rd_data = idle;
            ADR_PWRD:    rd_data = powered;
            ADR_ON_BUSY: rd_data = on_busy;
            ADR_OFF_BSY: rd_data = off_busy;
            ADR_VOTE:    rd_data = vote_view;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/hwv_vote_ctrl.sv
module hwv_vote_ctrl
    import hwv_pkg::*;
#(
    parameter int NUM_DOM    = 4,
    parameter int NUM_REQ    = 3,
    parameter int PREP_CYC   = 2,
    parameter int SETTLE_CYC = 100,
    parameter int IDW        = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDW-1:0]     wr_id,
    input  logic [2:0]         wr_addr,
    input  logic [NUM_DOM-1:0] wr_data,
    input  logic [IDW-1:0]     rd_id,
    input  logic [2:0]         rd_addr,
    output logic [NUM_DOM-1:0] rd_data,
    output logic [NUM_DOM-1:0] pwr_req,
    input  logic [NUM_DOM-1:0] pwr_ack
);
    logic                             wr_ok;
    logic [NUM_REQ-1:0]               req_oh;
    logic [NUM_DOM-1:0]               on_rb, off_rb, idle, powered, on_busy, off_busy;
    logic [NUM_DOM-1:0][NUM_REQ-1:0]  votes;

    assign wr_ok = wr_en && (int'(wr_id) < NUM_REQ);

    always_comb begin
        req_oh = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (int'(wr_id) == r) req_oh[r] = 1'b1;
        end
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic on_cmd, off_cmd;
        assign on_cmd  = wr_ok && (wr_addr == ADR_ON_CMD)  && wr_data[d];
        assign off_cmd = wr_ok && (wr_addr == ADR_OFF_CMD) && wr_data[d];

        hwv_domain #(
            .NUM_REQ   (NUM_REQ),
            .PREP_CYC  (PREP_CYC),
            .SETTLE_CYC(SETTLE_CYC)
        ) u_dom (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_on  (on_cmd),
            .cmd_off (off_cmd),
            .req_oh  (req_oh),
            .pwr_ack (pwr_ack[d]),
            .pwr_req (pwr_req[d]),
            .on_rb   (on_rb[d]),
            .off_rb  (off_rb[d]),
            .idle    (idle[d]),
            .powered (powered[d]),
            .on_busy (on_busy[d]),
            .off_busy(off_busy[d]),
            .votes   (votes[d])
        );
    end

    hwv_rd_mux #(
        .NUM_DOM(NUM_DOM),
        .NUM_REQ(NUM_REQ),
        .IDW    (IDW)
    ) u_rd (
        .rd_addr (rd_addr),
        .rd_id   (rd_id),
        .on_rb   (on_rb),
        .off_rb  (off_rb),
        .idle    (idle),
        .powered (powered),
        .on_busy (on_busy),
        .off_busy(off_busy),
        .votes   (votes),
        .rd_data (rd_data)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (pwr_req == '0));
endmodule

// File: tb/hwv_vote_ctrl_tb.sv
module hwv_vote_ctrl_tb;
    localparam int ND = 4;
    localparam int NR = 3;
    localparam int PC = 2;
    localparam int SC = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_id = '0;
    logic [2:0]    wr_addr = '0;
    logic [ND-1:0] wr_data = '0;
    logic [IW-1:0] rd_id = '0;
    logic [2:0]    rd_addr = '0;
    logic [ND-1:0] rd_data;
    logic [ND-1:0] pwr_req;
    logic [ND-1:0] pwr_ack;
    logic [ND-1:0] ack_s1, ack_s2, ack_s3;

    int n_run  = 0;
    int n_fail = 0;
    bit mon_busy = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0]    addr;
        logic [IW-1:0] id;
        logic [ND-1:0] exp;
        string         tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    hwv_vote_ctrl #(
        .NUM_DOM(ND), .NUM_REQ(NR), .PREP_CYC(PC), .SETTLE_CYC(SC), .IDW(IW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_id(wr_id), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_id(rd_id), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwr_req(pwr_req), .pwr_ack(pwr_ack)
    );

    // Power switch model: acknowledge follows the request three cycles late.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_s1 <= '0; ack_s2 <= '0; ack_s3 <= '0;
        end else begin
            ack_s1 <= pwr_req; ack_s2 <= ack_s1; ack_s3 <= ack_s2;
        end
    end
    assign pwr_ack = ack_s3;

    task automatic report(input logic [ND-1:0] got, input logic [ND-1:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Monitor: pops expected register values and compares them.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            begin
                sb_item_t it;
                mon_busy = 1'b1;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                rd_id   = it.id;
                #1;
                report(rd_data, it.exp, it.tag);
                mon_busy = 1'b0;
            end
        end
    end

    // Driver side of the scoreboard.
    task automatic expect_reg(input logic [2:0] addr, input logic [IW-1:0] id,
                              input logic [ND-1:0] exp, input string tag);
        sb_item_t it;
        it.addr = addr; it.id = id; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    task automatic do_write(input logic [IW-1:0] id, input logic [2:0] addr, input logic [ND-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_id = id; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Counts negedges after the write edge until the domain's idle bit is 1.
    task automatic wait_idle(input int dom, input int start, output int n);
        n = start;
        rd_addr = 3'd2;
        #1;
        while (rd_data[dom] !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
            rd_addr = 3'd2;
            #1;
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_reg(3'd0, 0, 4'b1111, "R1 on readback");
        expect_reg(3'd1, 0, 4'b0000, "R1 off readback");
        expect_reg(3'd2, 0, 4'b1111, "R1 idle");
        expect_reg(3'd3, 0, 4'b0000, "R1 powered");
        expect_reg(3'd4, 0, 4'b0000, "R1 on busy");
        expect_reg(3'd5, 0, 4'b0000, "R1 off busy");
        report(pwr_req, 4'b0000, "R1 pwr_req");
        expect_reg(3'd7, 0, 4'b0000, "R2 unused address");

        // Power up domain 0 from requester 0
        do_write(0, 3'd0, 4'b0001);
        expect_reg(3'd0, 0, 4'b1110, "R3 on readback cleared");
        expect_reg(3'd2, 0, 4'b1110, "R3 idle dropped");
        expect_reg(3'd4, 0, 4'b0001, "R3 on busy");
        expect_reg(3'd3, 0, 4'b0000, "R7 powered not on write");
        @(negedge clk); @(negedge clk);
        expect_reg(3'd0, 0, 4'b1111, "R3 on readback restored");
        expect_reg(3'd3, 0, 4'b0000, "R7 powered waits for ack");
        report(pwr_req, 4'b0001, "R6 request raised");
        // R5: write while busy is dropped
        do_write(1, 3'd0, 4'b0001);
        expect_reg(3'd6, 1, 4'b0000, "R5 busy write ignored");
        wait_idle(0, 5, n);
        expect_reg(3'd3, 0, 4'b0001, "R9 powered after up");
        expect_reg(3'd4, 0, 4'b0000, "R9 on busy cleared");
        expect_reg(3'd6, 0, 4'b0001, "R6 vote of req0");

        // Second voter joins
        do_write(1, 3'd0, 4'b0001);
        expect_reg(3'd2, 0, 4'b1110, "R3 second vote accepted");
        wait_idle(0, 1, n);
        expect_reg(3'd6, 1, 4'b0001, "R6 vote of req1");
        expect_reg(3'd3, 0, 4'b0001, "R6 still powered");

        // First voter leaves: domain stays on
        do_write(0, 3'd1, 4'b0001);
        expect_reg(3'd1, 0, 4'b0001, "R4 off readback set");
        expect_reg(3'd5, 0, 4'b0001, "R4 off busy");
        wait_idle(0, 1, n);
        expect_reg(3'd1, 0, 4'b0000, "R4 off readback cleared");
        expect_reg(3'd3, 0, 4'b0001, "R6 shared vote keeps power");
        report(pwr_req, 4'b0001, "R6 request held");

        // Last voter leaves: power down with settle
        do_write(1, 3'd1, 4'b0001);
        expect_reg(3'd1, 0, 4'b0001, "R4 off readback set again");
        @(negedge clk); @(negedge clk);
        expect_reg(3'd1, 0, 4'b0000, "R4 off readback after start");
        expect_reg(3'd3, 0, 4'b0001, "R7 powered during settle");
        report(pwr_req, 4'b0000, "R6 request dropped");
        wait_idle(0, 3, n);
        n_run++;
        if (n < PC + SC) begin
            n_fail++;
            $display("FAIL R8 settle: got %0d cycles expected at least %0d", n, PC + SC);
        end
        expect_reg(3'd3, 0, 4'b0000, "R9 powered cleared");
        expect_reg(3'd5, 0, 4'b0000, "R9 off busy cleared");

        // R10 multi-domain command
        do_write(2, 3'd0, 4'b1010);
        expect_reg(3'd2, 0, 4'b0101, "R10 two domains busy");
        wait_idle(1, 1, n);
        wait_idle(3, n, n);
        expect_reg(3'd3, 0, 4'b1010, "R10 both powered");
        expect_reg(3'd6, 2, 4'b1010, "R10 votes of req2");

        // R2: write to a status address changes nothing
        do_write(0, 3'd2, 4'b1111);
        expect_reg(3'd2, 0, 4'b1111, "R2 status write idle");
        expect_reg(3'd3, 0, 4'b1010, "R2 status write powered");

        // R5: out-of-range requester
        do_write(3, 3'd0, 4'b0001);
        expect_reg(3'd2, 0, 4'b1111, "R5 bad id idle");
        expect_reg(3'd3, 0, 4'b1010, "R5 bad id powered");

        // R10 one domain off, the other untouched
        do_write(2, 3'd1, 4'b1000);
        wait_idle(3, 1, n);
        expect_reg(3'd3, 0, 4'b0010, "R10 independent off");
        report(pwr_req, 4'b0010, "R10 request per domain");

        finish_up();
    end
endmodule